// File: doc/BRIEF.md
# Device-Side DMA Write Engine

This block sits inside a peripheral and copies words from that peripheral's data source into system memory without the processor touching each word. Software programs a destination byte address and a word count through a small register port, picks single or burst bus behaviour, and then sets a start bit. From then on the engine requests the system bus whenever a source word is waiting, writes that word once the bus is granted, and moves its address and count along.

In single mode the engine gives the bus back after every word. In burst mode it keeps the request raised from the first grant until the last word, so words go out back to back whenever the source and the grant allow. When the count reaches zero the engine clears its start bit, sets a done flag and holds its interrupt line high until software clears that flag. A start with a count of zero completes at once with no bus activity.

Register map (2-bit `reg_addr`): 0 = control, 1 = destination pointer (byte address), 2 = remaining word count (low `CNT_W` bits), 3 = reads as zero. Control bits: bit 0 = start/busy, bit 1 = burst select (1 = burst), bit 2 = done (write 1 to clear).

Top module: `dma_engine`

## Requirements
- R1: After reset the pointer, count and control registers read as zero, and `bus_req`, `mem_wr` and `irq` are low.
- R2: Before a control write with bit 0 set, a valid source word and an active grant cause no `bus_req` and no `mem_wr`, and the count stays as programmed.
- R3: Once started, a `src_valid` seen while waiting raises `bus_req` on the next clock; `mem_wr` is high only in a cycle where `bus_req`, `bus_gnt` and `src_valid` are all high, and `src_ready` equals `mem_wr`.
- R4: Each write drives `mem_addr` with the current pointer and `mem_wdata` with `src_data`; afterwards the pointer has grown by DATA_W/8 bytes and the count has dropped by one.
- R5: In single mode (control bit 1 = 0) `bus_req` is low in the cycle after every write that is not the last, so with source and grant always ready each word takes two cycles.
- R6: In burst mode (control bit 1 = 1) `bus_req` stays high from its rise until the last write, and with source and grant always ready one word is written every cycle.
- R7: The cycle after the write that brings the count to zero, `irq` is high, `bus_req` is low, control reads with bit 0 clear and bit 2 set, and the count reads zero.
- R8: `irq` stays high until a control write with bit 2 set, and is low the cycle after it.
- R9: A start with a count of zero sets done and `irq` on the next clock without ever raising `bus_req`, and leaves the pointer unchanged.
- R10: Writes to the pointer or count register while control bit 0 reads 1 leave both registers unchanged.
- R11: The number of memory writes in one run equals the programmed count, in words.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Read data of the selected register |
| src_valid | input | 1 | Peripheral has a word ready |
| src_data | input | DATA_W | Peripheral word |
| src_ready | output | 1 | Word taken this cycle |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| irq | output | 1 | Completion interrupt, held until cleared |

## Verification
Transfers of random length, destination and mode run against a source and grant that come and go at random, which shows whether address stepping and counting stay right when writes are spread out and interleaved with lost grants. Runs with source and grant always ready separate the two modes by their cycle cost: two cycles per word in single mode against one in burst mode. Directed cases cover the one-word transfer in both modes, the zero-count start, stimulus before the start bit, and register writes while busy, each of which tells apart a correct engine from one that starts early, miscounts by one, or lets software disturb a live transfer.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_REQ  = 2'd2
    } dma_state_e;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_PTR  = 2'd1;
    localparam logic [1:0] REG_CNT  = 2'd2;

    localparam int CTL_GO    = 0;
    localparam int CTL_BURST = 1;
    localparam int CTL_DONE  = 2;

endpackage

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mode_we,
    input  logic mode_val,
    input  logic done_clr,
    input  logic cnt_zero,
    input  logic cnt_last,
    input  logic src_valid,
    input  logic bus_gnt,
    output logic bus_req,
    output logic mem_wr,
    output logic busy,
    output logic burst,
    output logic done
);

    typedef struct packed {
        dma_state_e state;
        logic       burst;
        logic       done;
    } seq_t;

    seq_t s_d, s_q;
    logic wr_now;

    always_comb begin
        s_d    = s_q;
        wr_now = (s_q.state == ST_REQ) && bus_gnt && src_valid;

        if (mode_we)  s_d.burst = mode_val;
        if (done_clr) s_d.done  = 1'b0;

        unique case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (cnt_zero) s_d.done  = 1'b1;
                    else          s_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (src_valid) s_d.state = ST_REQ;
            end
            ST_REQ: begin
                if (wr_now) begin
                    if (cnt_last) begin
                        s_d.state = ST_IDLE;
                        s_d.done  = 1'b1;
                    end else if (!s_q.burst) begin
                        s_d.state = ST_WAIT;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, burst: 1'b0, done: 1'b0};
        else        s_q <= s_d;
    end

    assign bus_req = (s_q.state == ST_REQ);
    assign mem_wr  = wr_now;
    assign busy    = (s_q.state != ST_IDLE);
    assign burst   = s_q.burst;
    assign done    = s_q.done;

endmodule

// File: rtl/dma_ptrcnt.sv
module dma_ptrcnt #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_ptr,
    input  logic              ld_cnt,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr,
    output logic [CNT_W-1:0]  cnt,
    output logic              cnt_zero,
    output logic              cnt_last
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);
    localparam logic [CNT_W-1:0]  ONE_V  = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic [CNT_W-1:0]  cnt;
    } pc_t;

    pc_t pc_d, pc_q;

    always_comb begin
        pc_d = pc_q;
        if (adv) begin
            pc_d.ptr = pc_q.ptr + STEP_V;
            pc_d.cnt = pc_q.cnt - ONE_V;
        end else begin
            if (ld_ptr) pc_d.ptr = wdata;
            if (ld_cnt) pc_d.cnt = wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign ptr      = pc_q.ptr;
    assign cnt      = pc_q.cnt;
    assign cnt_zero = (pc_q.cnt == '0);
    assign cnt_last = (pc_q.cnt == ONE_V);

endmodule

// File: rtl/dma_rdmux.sv
module dma_rdmux
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              busy,
    input  logic              burst,
    input  logic              done,
    output logic [ADDR_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        unique case (sel)
            REG_CTRL: begin
                rdata[CTL_GO]    = busy;
                rdata[CTL_BURST] = burst;
                rdata[CTL_DONE]  = done;
            end
            REG_PTR: rdata = ptr;
            REG_CNT: rdata[CNT_W-1:0] = cnt;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              irq
);

    localparam int BYTES = DATA_W / 8;

    logic              busy, burst_mode, done;
    logic              ctl_wr, start, mode_we, done_clr, ld_ptr, ld_cnt;
    logic              cnt_zero, cnt_last;
    logic [ADDR_W-1:0] ptr_q;
    logic [CNT_W-1:0]  cnt_q;

    assign ctl_wr   = reg_wr && (reg_addr == REG_CTRL);
    assign start    = ctl_wr && reg_wdata[CTL_GO] && !busy;
    assign mode_we  = ctl_wr && !busy;
    assign done_clr = ctl_wr && reg_wdata[CTL_DONE];
    assign ld_ptr   = reg_wr && (reg_addr == REG_PTR) && !busy;
    assign ld_cnt   = reg_wr && (reg_addr == REG_CNT) && !busy;

    dma_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode_we   (mode_we),
        .mode_val  (reg_wdata[CTL_BURST]),
        .done_clr  (done_clr),
        .cnt_zero  (cnt_zero),
        .cnt_last  (cnt_last),
        .src_valid (src_valid),
        .bus_gnt   (bus_gnt),
        .bus_req   (bus_req),
        .mem_wr    (mem_wr),
        .busy      (busy),
        .burst     (burst_mode),
        .done      (done)
    );

    dma_ptrcnt #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .STEP   (BYTES)
    ) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_ptr   (ld_ptr),
        .ld_cnt   (ld_cnt),
        .wdata    (reg_wdata),
        .adv      (mem_wr),
        .ptr      (ptr_q),
        .cnt      (cnt_q),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last)
    );

    dma_rdmux #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_rd (
        .sel   (reg_addr),
        .ptr   (ptr_q),
        .cnt   (cnt_q),
        .busy  (busy),
        .burst (burst_mode),
        .done  (done),
        .rdata (reg_rdata)
    );

    assign src_ready = mem_wr;
    assign mem_addr  = ptr_q;
    assign mem_wdata = src_data;
    assign irq       = done;

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int STEP   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_wr,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              src_valid,
    input logic              irq,
    input logic              busy,
    input logic              burst_mode,
    input logic              done_clr,
    input logic              ld_try_ptr,
    input logic              ld_try_cnt,
    input logic [ADDR_W-1:0] ptr_q,
    input logic [CNT_W-1:0]  cnt_q
);

    assert_req_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy);

    assert_wr_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (bus_req && bus_gnt && src_valid));

    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (ptr_q == $past(ptr_q) + ADDR_W'(STEP)));

    assert_cnt_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    assert_single_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !burst_mode) |=> !bus_req);

    assert_burst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && burst_mode && !mem_wr) |=> bus_req);

    assert_finish_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && cnt_q == CNT_W'(1)) |=> (irq && !busy && !bus_req));

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !done_clr) |=> irq);

    assert_busy_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ld_try_ptr && !mem_wr) |=> $stable(ptr_q));

    assert_busy_cnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ld_try_cnt && !mem_wr) |=> $stable(cnt_q));

endmodule

bind dma_engine dma_engine_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .STEP   (DATA_W / 8)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_wr     (mem_wr),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .src_valid  (src_valid),
    .irq        (irq),
    .busy       (busy),
    .burst_mode (burst_mode),
    .done_clr   (done_clr),
    .ld_try_ptr (reg_wr && (reg_addr == 2'd1)),
    .ld_try_cnt (reg_wr && (reg_addr == 2'd2)),
    .ptr_q      (ptr_q),
    .cnt_q      (cnt_q)
);

// File: tb/dma_engine_tb.sv
module dma_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;
    localparam int BYTES = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          src_valid = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic          src_ready;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic          mem_wr;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_valid(src_valid),
        .src_data(src_data), .src_ready(src_ready), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .irq(irq)
    );

    function automatic logic [AW-1:0] end_ptr(input logic [AW-1:0] p, input int n);
        return p + AW'(n * BYTES);
    endfunction

    function automatic logic [AW-1:0] ctrl_val(input bit go, input bit bm, input bit dn);
        return AW'({dn, bm, go});
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [AW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [AW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // vmode 0: random source and grant, 1: always ready
    task automatic drive(input logic [AW-1:0] p, input int n, input bit bm,
                         input int vmode, output int cycles);
        logic [AW-1:0] exp_ptr = p;
        int  nwr = 0;
        bit  seen_req = 0;
        bit  prev_wr = 0;
        cycles = 0;
        while (nwr < n && cycles < 4000) begin
            src_valid = (vmode == 1) ? 1'b1 : (($urandom % 4) != 0);
            src_data  = $urandom;
            bus_gnt   = bus_req && ((vmode == 1) || (($urandom % 3) != 0));
            #1;
            check(src_ready == mem_wr, "R3 src_ready", src_ready, mem_wr);
            if (mem_wr) begin
                check(bus_req && bus_gnt, "R3 write without grant", bus_req, 1);
                check(mem_addr == exp_ptr, "R4 mem_addr", mem_addr, exp_ptr);
                check(mem_wdata == src_data, "R4 mem_wdata", mem_wdata, src_data);
                exp_ptr = exp_ptr + AW'(BYTES);
                nwr++;
            end
            if (!bm && prev_wr && nwr < n)
                check(!bus_req, "R5 request released", bus_req, 0);
            if (bm && seen_req)
                check(bus_req, "R6 request held", bus_req, 1);
            seen_req = seen_req || bus_req;
            prev_wr = mem_wr;
            @(negedge clk);
            cycles++;
        end
        src_valid = 1'b0;
        bus_gnt   = 1'b0;
        #1;
        check(nwr == n, "R11 write count", nwr, n);
        check(irq, "R7 irq at end", irq, 1);
        check(!bus_req, "R7 bus released", bus_req, 0);
        check(!mem_wr, "R7 no extra write", mem_wr, 0);
    endtask

    task automatic finish_checks(input logic [AW-1:0] p, input int n, input bit bm);
        logic [AW-1:0] d;
        reg_read(2'd1, d); check(d == end_ptr(p, n), "R4 final pointer", d, end_ptr(p, n));
        reg_read(2'd2, d); check(d == 0, "R7 final count", d, 0);
        reg_read(2'd0, d); check(d == ctrl_val(0, bm, 1), "R7 control", d, ctrl_val(0, bm, 1));
        @(negedge clk); @(negedge clk);
        check(irq, "R8 irq held", irq, 1);
        reg_write(2'd0, ctrl_val(0, 0, 1));
        #1;
        check(!irq, "R8 irq cleared", irq, 0);
    endtask

    task automatic run_xfer(input logic [AW-1:0] p, input int n, input bit bm,
                            input int vmode, output int cycles);
        reg_write(2'd1, p);
        reg_write(2'd2, AW'(n));
        reg_write(2'd0, ctrl_val(1, bm, 0));
        drive(p, n, bm, vmode, cycles);
        finish_checks(p, n, bm);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] d;
        int cyc;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(2'd0, d); check(d == 0, "R1 control", d, 0);
        reg_read(2'd1, d); check(d == 0, "R1 pointer", d, 0);
        reg_read(2'd2, d); check(d == 0, "R1 count", d, 0);
        check(!bus_req && !mem_wr && !irq, "R1 outputs", {bus_req, mem_wr, irq}, 0);

        // R2 no activity before start
        reg_write(2'd1, 32'h0000_2000);
        reg_write(2'd2, 32'd2);
        src_valid = 1'b1; bus_gnt = 1'b1;
        for (int i = 0; i < 5; i++) begin
            #1;
            check(!bus_req && !mem_wr, "R2 idle bus", {bus_req, mem_wr}, 0);
            @(negedge clk);
        end
        src_valid = 1'b0; bus_gnt = 1'b0;
        reg_read(2'd2, d); check(d == 2, "R2 count kept", d, 2);

        // R9 zero count start
        reg_write(2'd1, 32'h0000_3000);
        reg_write(2'd2, 32'd0);
        reg_write(2'd0, ctrl_val(1, 0, 0));
        #1;
        check(irq, "R9 irq", irq, 1);
        check(!bus_req, "R9 no request", bus_req, 0);
        reg_read(2'd0, d); check(d == ctrl_val(0, 0, 1), "R9 control", d, ctrl_val(0, 0, 1));
        reg_read(2'd1, d); check(d == 32'h3000, "R9 pointer", d, 32'h3000);
        @(negedge clk); #1;
        check(!bus_req, "R9 still no request", bus_req, 0);
        reg_write(2'd0, ctrl_val(0, 0, 1));
        #1; check(!irq, "R8 clear after zero", irq, 0);

        // R10 busy writes ignored
        reg_write(2'd1, 32'h0000_0100);
        reg_write(2'd2, 32'd3);
        reg_write(2'd0, ctrl_val(1, 0, 0));
        reg_write(2'd1, 32'hDEAD_0000);
        reg_write(2'd2, 32'd99);
        reg_read(2'd1, d); check(d == 32'h100, "R10 pointer kept", d, 32'h100);
        reg_read(2'd2, d); check(d == 3, "R10 count kept", d, 3);
        reg_read(2'd0, d); check(d == ctrl_val(1, 0, 0), "R10 busy bit", d, ctrl_val(1, 0, 0));
        drive(32'h100, 3, 0, 0, cyc);
        finish_checks(32'h100, 3, 0);

        // single-word corner in both modes
        run_xfer(32'h0000_4000, 1, 0, 0, cyc);
        run_xfer(32'h0000_5000, 1, 1, 0, cyc);

        // cycle cost with source and grant always ready
        run_xfer(32'h0001_0000, 6, 1, 1, cyc);
        check(cyc == 7, "R6 back-to-back burst cycles", cyc, 7);
        run_xfer(32'h0002_0000, 6, 0, 1, cyc);
        check(cyc == 12, "R5 single-mode cycles", cyc, 12);

        // random transfers, including an address wrap
        run_xfer(32'hFFFF_FFF8, 4, 1, 0, cyc);
        for (int t = 0; t < 24; t++) begin
            logic [AW-1:0] p = $urandom & 32'hFFFF_FFFC;
            int n = 1 + ($urandom % 10);
            bit bm = $urandom % 2;
            run_xfer(p, n, bm, 0, cyc);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule